// File: doc/BRIEF.md
# PLL Phase Lock Monitor

This block watches a phase-locked loop from the outside. It takes the reference clock and the feedback clock, both already divided down to the phase-detector rate. It brings each one into a fast sampling clock domain and finds its rising edges. It then pairs one reference edge with one feedback edge and counts the sampling ticks between them. The result is a signed error: positive when the feedback edge comes after the reference edge, negative when it comes first.

The block reports loss of lock and regain of lock with two different thresholds. One large deviation, or a missing partner edge, raises the loss-of-lock flag at once. Lock is declared again only after a run of consecutive measurements that all stay inside a much tighter window. When the run completes, a one-cycle qualified-lock strobe is sent to a downstream sequencer, which can use it, for example, to start a bandwidth-restore timer.

The measured error leaves the block as an output stream with a valid strobe and no ready. The measurement is paced by the two clocks and cannot be held back, so a consumer must take each value in the cycle where `err_valid` is high. The loss-of-lock flag and the lock strobe are plain status pins.

Top module: `phase_lock_monitor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `lol` is 1, `lock_ok` is 0 and `err_valid` is 0.
- R2: The raw inputs pass through a two-flop synchroniser and a rising-edge detector. Each rising edge on a raw input is used exactly once. `err` is the two's-complement count of sampling ticks from the reference edge to the feedback edge. A feedback edge that comes later gives a positive value, and edges in the same cycle give 0. `err_valid` goes high three clocks after the later of the two raw inputs is sampled high.
- R3: `err_valid` is a single-cycle pulse, issued once for each paired measurement. There is no back-pressure.
- R4: A measurement with |err| >= `LOSS_TICKS` (4 by default) sets `lol` to 1 and clears the good-run count. Both take effect one clock after `err_valid`.
- R5: A measurement with |err| <= `HOLD_TICKS` (2 by default) adds one to the good-run count. The count stops at `GOOD_RUN` (8 by default) and goes no higher.
- R6: A measurement with `HOLD_TICKS` < |err| < `LOSS_TICKS` clears the good-run count and leaves `lol` unchanged.
- R7: When the good-run count reaches `GOOD_RUN`, `lock_ok` pulses for one cycle, and in that same cycle `lol` goes to 0.
- R8: If an edge waits `TIMEOUT_TICKS` ticks without a partner, or no edge arrives at all for that long, `lol` is set to 1 and the good-run count is cleared. No `err_valid` is issued for the unpaired edge.
- R9: Once the count has stopped at `GOOD_RUN`, further good measurements produce no further `lock_ok` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_raw | input | 1 | Divided reference clock, asynchronous |
| fb_raw | input | 1 | Divided feedback clock, asynchronous |
| lol | output | 1 | Loss-of-lock flag |
| lock_ok | output | 1 | One-cycle strobe when lock is qualified |
| err_valid | output | 1 | Valid strobe for `err` |
| err | output | ERR_W | Signed edge separation in ticks |

## Verification
The bench sweeps every separation from -6 to +6 ticks in both directions, with each value applied twice in a row. This separates the three error bands (tight, intermediate and large) at the exact boundary values 2, 3 and 4, and it checks the sign convention. Runs of zero error and of alternating ±2 error show that lock is qualified on exactly the eighth good measurement and that the count then stops without a second strobe. A phase in which the feedback clock is silenced, followed by a recovery, shows that a missing edge declares loss of lock without producing a measurement, and that the good run starts again from zero afterwards.

// File: rtl/plm_pkg.sv
package plm_pkg;
  typedef enum logic [1:0] {
    PAIR_IDLE    = 2'd0,
    PAIR_WAIT_FB = 2'd1,
    PAIR_WAIT_RF = 2'd2
  } pair_state_e;

  localparam int CH_REF = 0;
  localparam int CH_FB  = 1;
  localparam int N_CH   = 2;
endpackage

// File: rtl/plm_edge_sync.sv
module plm_edge_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= raw_i[g];
        s2 <= s1;
        s3 <= s2;
      end
    end

    assign rise_o[g] = s2 & ~s3;

    // R2
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/plm_pair_meter.sv
module plm_pair_meter
  import plm_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 64,
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1),
  localparam int ERR_W = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_rise,
  input  logic                    fb_rise,
  output logic                    meas_valid,
  output logic signed [ERR_W-1:0] meas_err,
  output logic                    miss
);
  pair_state_e st;
  logic [CNT_W-1:0] cnt;
  logic             tmo;

  assign tmo = (cnt == CNT_W'(TIMEOUT_TICKS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= PAIR_IDLE;
      cnt        <= '0;
      meas_valid <= 1'b0;
      meas_err   <= '0;
      miss       <= 1'b0;
    end else begin
      meas_valid <= 1'b0;
      miss       <= 1'b0;
      case (st)
        PAIR_IDLE: begin
          if (ref_rise && fb_rise) begin
            meas_valid <= 1'b1;
            meas_err   <= '0;
            cnt        <= '0;
          end else if (ref_rise) begin
            st  <= PAIR_WAIT_FB;
            cnt <= CNT_W'(1);
          end else if (fb_rise) begin
            st  <= PAIR_WAIT_RF;
            cnt <= CNT_W'(1);
          end else if (tmo) begin
            miss <= 1'b1;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PAIR_WAIT_FB: begin
          if (fb_rise) begin
            meas_valid <= 1'b1;
            meas_err   <= $signed({1'b0, cnt});
            st         <= PAIR_IDLE;
            cnt        <= '0;
          end else if (tmo) begin
            miss <= 1'b1;
            st   <= PAIR_IDLE;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PAIR_WAIT_RF: begin
          if (ref_rise) begin
            meas_valid <= 1'b1;
            meas_err   <= -$signed({1'b0, cnt});
            st         <= PAIR_IDLE;
            cnt        <= '0;
          end else if (tmo) begin
            miss <= 1'b1;
            st   <= PAIR_IDLE;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          st  <= PAIR_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  // R3
  valid_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_valid && miss));

  // R8
  miss_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> !miss);
endmodule

// File: rtl/plm_lock_qual.sv
module plm_lock_qual #(
  parameter int ERR_W      = 8,
  parameter int LOSS_TICKS = 4,
  parameter int HOLD_TICKS = 2,
  parameter int GOOD_RUN   = 8,
  localparam int RUN_W = $clog2(GOOD_RUN + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    meas_valid,
  input  logic signed [ERR_W-1:0] meas_err,
  input  logic                    miss,
  output logic                    lol,
  output logic                    lock_ok
);
  logic [ERR_W-1:0] mag;
  logic [RUN_W-1:0] run;
  logic             big, tight;

  always_comb begin
    mag   = meas_err[ERR_W-1] ? ERR_W'(-meas_err) : ERR_W'(meas_err);
    big   = (mag >= ERR_W'(LOSS_TICKS));
    tight = (mag <= ERR_W'(HOLD_TICKS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lol     <= 1'b1;
      lock_ok <= 1'b0;
      run     <= '0;
    end else begin
      lock_ok <= 1'b0;
      if (miss) begin
        lol <= 1'b1;
        run <= '0;
      end else if (meas_valid) begin
        if (big) begin
          lol <= 1'b1;
          run <= '0;
        end else if (tight) begin
          if (run == RUN_W'(GOOD_RUN - 1)) begin
            run     <= RUN_W'(GOOD_RUN);
            lock_ok <= 1'b1;
            lol     <= 1'b0;
          end else if (run != RUN_W'(GOOD_RUN)) begin
            run <= run + 1'b1;
          end
        end else begin
          run <= '0;
        end
      end
    end
  end

  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_W'(GOOD_RUN));

  // R7
  lock_clears_lol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ok |-> !lol);

  // R9
  lock_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ok |=> !lock_ok);

  // R4
  lol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lol) |-> $past(meas_valid || miss));
endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
  import plm_pkg::*;
#(
  parameter int LOSS_TICKS    = 4,
  parameter int HOLD_TICKS    = 2,
  parameter int GOOD_RUN      = 8,
  parameter int TIMEOUT_TICKS = 64,
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1),
  localparam int ERR_W = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_raw,
  input  logic                    fb_raw,
  output logic                    lol,
  output logic                    lock_ok,
  output logic                    err_valid,
  output logic signed [ERR_W-1:0] err
);
  logic [N_CH-1:0] raw_v, rise_v;
  logic            miss;

  assign raw_v[CH_REF] = ref_raw;
  assign raw_v[CH_FB]  = fb_raw;

  plm_edge_sync #(.N(N_CH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw_v),
    .rise_o (rise_v)
  );

  plm_pair_meter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_rise   (rise_v[CH_REF]),
    .fb_rise    (rise_v[CH_FB]),
    .meas_valid (err_valid),
    .meas_err   (err),
    .miss       (miss)
  );

  plm_lock_qual #(
    .ERR_W      (ERR_W),
    .LOSS_TICKS (LOSS_TICKS),
    .HOLD_TICKS (HOLD_TICKS),
    .GOOD_RUN   (GOOD_RUN)
  ) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_valid (err_valid),
    .meas_err   (err),
    .miss       (miss),
    .lol        (lol),
    .lock_ok    (lock_ok)
  );
endmodule

// File: tb/phase_lock_monitor_tb.sv
module phase_lock_monitor_tb;
  localparam int ERR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_raw = 1'b0;
  logic fb_raw = 1'b0;
  logic lol, lock_ok, err_valid;
  logic signed [ERR_W-1:0] err;

  int checks = 0;
  int errors = 0;
  int n_valid = 0;
  int n_lock = 0;
  int last_err = 0;
  int m_run = 0;
  bit m_lol = 1'b1;

  always #4 clk = ~clk;

  phase_lock_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .ref_raw(ref_raw), .fb_raw(fb_raw),
    .lol(lol), .lock_ok(lock_ok), .err_valid(err_valid), .err(err)
  );

  always @(negedge clk) begin
    if (err_valid) begin
      n_valid++;
      last_err = int'(err);
    end
    if (lock_ok) n_lock++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One phase-detector period of 20 ticks; fb edge offset d from ref edge.
  task automatic window(input int d, input bit ref_on, input bit fb_on);
    int v0 = 0, l0 = 0, mag, exp_pulse;
    string tag;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (t == 0) begin
        v0 = n_valid;
        l0 = n_lock;
      end
      ref_raw = ref_on && (t >= 7) && (t < 16);
      fb_raw  = fb_on && (t >= 7 + d) && (t < 16);
    end
    if (ref_on && fb_on) begin
      mag = (d < 0) ? -d : d;
      exp_pulse = 0;
      if (mag >= 4) begin
        m_lol = 1'b1; m_run = 0; tag = "R4";
      end else if (mag <= 2) begin
        tag = (m_run == 8) ? "R9" : "R5";
        if (m_run == 7) begin
          m_lol = 1'b0; exp_pulse = 1; tag = "R7";
        end
        if (m_run < 8) m_run++;
      end else begin
        m_run = 0; tag = "R6";
      end
      check(n_valid - v0 == 1, "R3", n_valid - v0, 1);
      check(last_err == d, "R2", last_err, d);
      check(lol == m_lol, tag, int'(lol), int'(m_lol));
      check(n_lock - l0 == exp_pulse, tag, n_lock - l0, exp_pulse);
    end else begin
      check(n_valid - v0 == 0, "R8", n_valid - v0, 0);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(lol == 1'b1, "R1", int'(lol), 1);
    check(lock_ok == 1'b0, "R1", int'(lock_ok), 0);
    check(err_valid == 1'b0, "R1", int'(err_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(lol == 1'b1 && lock_ok == 1'b0 && err_valid == 1'b0, "R1", int'(lol), 1);

    // zero error run: lock on eighth, saturate on ninth and tenth
    for (int i = 0; i < 10; i++) window(0, 1'b1, 1'b1);
    window(3, 1'b1, 1'b1);   // intermediate band, lol stays low
    window(-3, 1'b1, 1'b1);
    window(-4, 1'b1, 1'b1);  // large, lol high
    // full sweep, each value twice
    for (int d = -6; d <= 6; d++) begin
      window(d, 1'b1, 1'b1);
      window(d, 1'b1, 1'b1);
    end
    // alternating +/-2 relock
    for (int i = 0; i < 10; i++) window((i % 2 == 0) ? 2 : -2, 1'b1, 1'b1);

    // feedback silenced
    for (int i = 0; i < 4; i++) window(0, 1'b1, 1'b0);
    check(lol == 1'b1, "R8", int'(lol), 1);
    repeat (120) @(negedge clk);
    check(lol == 1'b1, "R8", int'(lol), 1);
    m_lol = 1'b1;
    m_run = 0;
    // recovery from zero count
    for (int i = 0; i < 9; i++) window(1, 1'b1, 1'b1);
    for (int i = 0; i < 9; i++) window(-1, 1'b1, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule